// File: doc/BRIEF.md
# Closed-Loop Event Crossing Synchronizer

This block carries single events from one clock domain into another clock domain that runs independently of it. A one-cycle pulse on the source side raises a request level, and that level stays high. The level passes through a chain of synchronizer flops into the destination domain. The last flop of that chain is the acknowledge, and it travels back through a second chain into the source domain. The source lowers its request only when the returned acknowledge is high. It then waits for the acknowledge to return low before it takes the next event.

The destination side gives one single-cycle strobe for each event that crossed. The source side reports `src_busy` for as long as a crossing is in progress. A pulse that arrives while busy is high is discarded, and a sticky flag records that this happened. A full crossing takes several cycles of each clock, so the block suits infrequent control events.

Top module: `hs_pulse_handshake`

## Requirements
- R1: During and right after a reset, `src_busy`, `src_dropped` and `dst_event` are all low.
- R2: A `src_pulse` seen high at a `src_clk` edge while `src_busy` is low is accepted, and `src_busy` is high after that same edge.
- R3: Each accepted pulse produces exactly one `dst_event` strobe, and no strobe appears without an accepted pulse.
- R4: `dst_event` is never high for two consecutive `dst_clk` cycles.
- R5: Once raised, `src_busy` stays high for at least 2*SYNC_STAGES consecutive `src_clk` cycles, covering the request and acknowledge round trip.
- R6: A `src_pulse` seen while `src_busy` is high is ignored: it produces no `dst_event` and sets `src_dropped`.
- R7: `src_dropped`, once set, stays high until `src_rst`.
- R8: The source request stays high until the synchronized acknowledge is high, and it falls only in the cycle after the acknowledge has been seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst | input | 1 | Source domain synchronous reset, active high |
| src_pulse | input | 1 | Event request, one cycle wide |
| src_busy | output | 1 | A crossing is in progress; new pulses are discarded |
| src_dropped | output | 1 | Sticky: a pulse was discarded while busy |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst | input | 1 | Destination domain synchronous reset, active high |
| dst_event | output | 1 | One-cycle strobe per event that crossed |

## Verification
A stuck or misordered handshake state shows at the ports in one of three ways. A lost or doubled event makes the count of `dst_event` strobes differ from the count of accepted pulses, and this is visible within one round trip. A request that is dropped too early shortens `src_busy` below its minimum length, which is seen when busy falls. A state that never leaves its busy phase holds `src_busy` high indefinitely, so the idle wait after each phase catches it.

// File: rtl/hs_pkg.sv
`timescale 1ns/1ps
package hs_pkg;
  localparam int HS_MIN_STAGES = 2;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_REQ   = 2'd1,
    HS_DRAIN = 2'd2
  } hs_state_e;
endpackage

// File: rtl/hs_sync_chain.sv
`timescale 1ns/1ps
module hs_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] ff;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) ff[0] <= 1'b0;
          else     ff[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) ff[g] <= 1'b0;
          else     ff[g] <= ff[g-1];
        end
      end
    end
  endgenerate

  assign q = ff[LAST];
endmodule

// File: rtl/hs_src_side.sv
`timescale 1ns/1ps
module hs_src_side
  import hs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pulse,
  input  logic ack_s,
  output logic req,
  output logic busy,
  output logic dropped
);
  hs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_IDLE:  if (pulse) state_d = HS_REQ;
      HS_REQ:   if (ack_s) state_d = HS_DRAIN;
      HS_DRAIN: if (!ack_s) state_d = HS_IDLE;
      default:  state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= HS_IDLE;
      req     <= 1'b0;
      busy    <= 1'b0;
      dropped <= 1'b0;
    end else begin
      state_q <= state_d;
      req     <= (state_d == HS_REQ);
      busy    <= (state_d != HS_IDLE);
      if (pulse && busy) dropped <= 1'b1;
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (pulse && !busy) |=> busy); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (req && !ack_s) |=> req); // R8
  AST_REQ_FALL_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    $fell(req) |-> $past(ack_s)); // R8
  AST_DROP_STICKY: assert property (@(posedge clk) disable iff (rst)
    dropped |=> dropped); // R7
  AST_DROP_SET: assert property (@(posedge clk) disable iff (rst)
    (pulse && busy) |=> dropped); // R6
endmodule

// File: rtl/hs_dst_side.sv
`timescale 1ns/1ps
module hs_dst_side #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_async,
  output logic ack,
  output logic event_o
);
  logic lvl;
  logic lvl_d;

  hs_sync_chain #(.STAGES(STAGES)) u_req_sync (
    .clk (clk),
    .rst (rst),
    .d   (req_async),
    .q   (lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_d   <= 1'b0;
      event_o <= 1'b0;
    end else begin
      lvl_d   <= lvl;
      event_o <= lvl & ~lvl_d;
    end
  end

  assign ack = lvl;

  AST_EVENT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    event_o |=> !event_o); // R4
  AST_EVENT_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(event_o) |-> $past(lvl)); // R3
endmodule

// File: rtl/hs_pulse_handshake.sv
`timescale 1ns/1ps
module hs_pulse_handshake #(
  parameter int SYNC_STAGES = 2
) (
  input  logic src_clk,
  input  logic src_rst,
  input  logic src_pulse,
  output logic src_busy,
  output logic src_dropped,
  input  logic dst_clk,
  input  logic dst_rst,
  output logic dst_event
);
  localparam int STAGES = (SYNC_STAGES < hs_pkg::HS_MIN_STAGES) ?
                          hs_pkg::HS_MIN_STAGES : SYNC_STAGES;

  logic req;
  logic ack;
  logic ack_s;

  hs_src_side u_src (
    .clk     (src_clk),
    .rst     (src_rst),
    .pulse   (src_pulse),
    .ack_s   (ack_s),
    .req     (req),
    .busy    (src_busy),
    .dropped (src_dropped)
  );

  hs_dst_side #(.STAGES(STAGES)) u_dst (
    .clk       (dst_clk),
    .rst       (dst_rst),
    .req_async (req),
    .ack       (ack),
    .event_o   (dst_event)
  );

  hs_sync_chain #(.STAGES(STAGES)) u_ack_sync (
    .clk (src_clk),
    .rst (src_rst),
    .d   (ack),
    .q   (ack_s)
  );

  AST_RESET_QUIET: assert property (@(posedge src_clk)
    $past(src_rst) |-> (!src_busy && !src_dropped)); // R1
endmodule

// File: tb/hs_pulse_handshake_test.sv
`timescale 1ns/1ps
module hs_pulse_handshake_test;
  localparam int CLK_PERIOD = 10;
  localparam int STAGES = 2;

  logic src_clk = 1'b0, dst_clk = 1'b0;
  logic src_rst = 1'b1, dst_rst = 1'b1;
  logic src_pulse = 1'b0;
  logic src_busy, src_dropped, dst_event;
  int   dst_half = 7;

  int checks = 0, errors = 0;
  int accepted = 0, events = 0;
  bit exp_dropped = 0;
  bit ev_prev = 0;
  int busy_run = 0;

  hs_pulse_handshake #(.SYNC_STAGES(STAGES)) uut (
    .src_clk(src_clk), .src_rst(src_rst), .src_pulse(src_pulse),
    .src_busy(src_busy), .src_dropped(src_dropped),
    .dst_clk(dst_clk), .dst_rst(dst_rst), .dst_event(dst_event)
  );

  always #(CLK_PERIOD/2) src_clk = ~src_clk;
  always #(dst_half) dst_clk = ~dst_clk;

  function automatic bit exp_accept(bit busy_before, bit pulse);
    return pulse && !busy_before;
  endfunction

  function automatic int min_busy(int stages);
    return 2 * stages;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R4 / R3 monitor on the destination side
  always @(negedge dst_clk) begin
    if (dst_rst) ev_prev = 0;
    else begin
      if (dst_event) begin
        events++;
        check(!ev_prev, "R4 strobe width", 2, 1);
      end
      ev_prev = dst_event;
    end
  end

  // R5 monitor: busy length in source cycles
  always @(negedge src_clk) begin
    if (src_rst) busy_run = 0;
    else if (src_busy) busy_run++;
    else if (busy_run > 0) begin
      check(busy_run >= min_busy(STAGES), "R5 busy length", busy_run, min_busy(STAGES));
      busy_run = 0;
    end
  end

  task automatic send_pulse();
    bit b;
    @(negedge src_clk);
    b = src_busy;
    src_pulse = 1'b1;
    @(negedge src_clk);
    src_pulse = 1'b0;
    if (exp_accept(b, 1'b1)) begin
      accepted++;
      check(src_busy == 1'b1, "R2 busy after accept", src_busy, 1);
    end else begin
      exp_dropped = 1;
      check(src_dropped == 1'b1, "R6 dropped flag", src_dropped, 1);
    end
  endtask

  task automatic wait_idle();
    int t = 0;
    while (src_busy && t < 2000) begin
      @(negedge src_clk);
      t++;
    end
    check(!src_busy, "R5 busy returns low", src_busy, 0);
    repeat (4) @(negedge dst_clk);
    check(events == accepted, "R3 event count", events, accepted);
    check(src_dropped == exp_dropped, "R7 dropped state", src_dropped, exp_dropped);
  endtask

  task automatic do_reset();
    src_rst = 1'b1;
    dst_rst = 1'b1;
    repeat (4) @(negedge src_clk);
    repeat (4) @(negedge dst_clk);
    @(negedge src_clk);
    src_rst = 1'b0;
    dst_rst = 1'b0;
    @(negedge src_clk);
    check(!src_busy, "R1 busy after reset", src_busy, 0);
    check(!src_dropped, "R1 dropped after reset", src_dropped, 0);
    check(!dst_event, "R1 event after reset", dst_event, 0);
    accepted = 0;
    events = 0;
    exp_dropped = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();

    // directed: single pulse, then wait
    send_pulse();
    wait_idle();
    check(!src_dropped, "R6 no drop on clean transfer", src_dropped, 0);

    // directed: back-to-back pulses, second is dropped (R6)
    send_pulse();
    send_pulse();
    wait_idle();
    check(accepted == 2, "R6 ignored pulse not counted", accepted, 2);

    // R7: flag stays set across a long idle and another clean transfer
    repeat (50) @(negedge src_clk);
    send_pulse();
    wait_idle();
    check(src_dropped, "R7 sticky flag", src_dropped, 1);

    // R1: reset clears flag
    do_reset();

    // random phases at three clock ratios
    for (int ph = 0; ph < 3; ph++) begin
      dst_half = (ph == 0) ? 7 : (ph == 1) ? 3 : 17;
      repeat (4) @(negedge src_clk);
      for (int i = 0; i < 60; i++) begin
        repeat ($urandom % 30) @(negedge src_clk);
        send_pulse();
      end
      wait_idle();
    end

    // directed: pulse in the cycle right after busy falls is accepted
    send_pulse();
    while (src_busy) @(negedge src_clk);
    send_pulse();
    wait_idle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule